// File: doc/BRIEF.md
# MESI Snooping Line Controller

This block keeps the coherence state of a few lines of a private cache that sits on a shared snooping bus. Each cycle it can take one local event from the core side (read, write, eviction) and one snooped event from the bus side (read, write, upgrade). Both are addressed by tag, and each tag is matched against the lines it holds. For the addressed line it computes the next MESI state. In the same cycle it drives the bus request to issue, the snoop response (shared or dirty), a writeback command and an error flag for snoops that cannot legally happen.

A local miss takes the lowest-numbered Invalid line. When the controller issues a bus read, the sharer signal from the bus model is sampled in that same cycle, and it decides whether the filled line becomes Exclusive or Shared. Data storage, bus arbitration and memory timing are handled elsewhere. The state of the line addressed by the local tag is always visible on a lookup output, so software-free observation of the array is possible through the normal interface.

Top module: `mesi_line_ctrl`

## Requirements
- R1: States are encoded I=00, S=01, E=10, M=11. `loc_state` shows the state of the line holding `loc_tag`, or 00 if no valid line holds it. After a synchronous reset, every line is Invalid and all outputs are 0.
- R2: A local read (op 0) that misses issues a bus read (`bus_op`=1) in the same cycle. The line becomes E when `shared_in` is low in that cycle, and S when it is high.
- R3: A local write (op 1) that misses issues a bus write (`bus_op`=2) and the line becomes M. A local write to an S line issues a bus upgrade (`bus_op`=3) and the line becomes M.
- R4: A local write to an E line makes it M with `bus_op`=0. Local reads that hit in S, E or M, and local writes in M, produce no bus request and leave the state unchanged.
- R5: An eviction (op 2) of an M line raises `wb_valid` and makes the line I. An eviction of an S or E line makes it I without writeback. An eviction that misses does nothing.
- R6: A snooped read (op 0) that hits an S or E line raises `resp_shared`. E becomes S and S stays S.
- R7: A snooped read that hits an M line raises `resp_dirty` and `wb_valid`, and the line becomes S. A snooped write (op 1) that hits an M line raises the same two outputs, and the line becomes I.
- R8: A snooped write or snooped upgrade (op 2) that hits an S or E line makes it I, with no response and no writeback.
- R9: A snooped upgrade that hits an E or M line raises `err_flag` and leaves the state unchanged.
- R10: A snooped event whose tag is not held by any valid line produces no response, writeback or error.
- R11: When `snp_valid` is high, the local request of that cycle is ignored: there is no bus request and no state change from it.
- R12: A local read or write that misses while every line is valid is dropped: `bus_op`=0 and no line is allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loc_valid | input | 1 | Local event present |
| loc_op | input | 2 | Local event: 0 read, 1 write, 2 evict, 3 none |
| loc_tag | input | TAG_W | Tag of the local event, also the lookup tag |
| shared_in | input | 1 | Sharer signal from the bus, sampled on a fill |
| snp_valid | input | 1 | Snooped event present |
| snp_op | input | 2 | Snooped event: 0 read, 1 write, 2 upgrade, 3 none |
| snp_tag | input | TAG_W | Tag of the snooped event |
| bus_op | output | 2 | Bus request: 0 none, 1 read, 2 write, 3 upgrade |
| resp_shared | output | 1 | Shared snoop response |
| resp_dirty | output | 1 | Dirty snoop response |
| wb_valid | output | 1 | Write the line's data back to memory |
| err_flag | output | 1 | Illegal snoop seen |
| loc_state | output | 2 | Current state of the line matching `loc_tag` |

## Verification
Because all actions are combinational on the current state, a wrong stored state shows up at the ports the very next time that line is touched. It appears as a wrong `loc_state` on a lookup one cycle after the update, or as a missing or spurious upgrade, dirty response or error on the next event. The bench follows each event with a lookup of the same tag, so a bad transition surfaces within two cycles. A wrong allocation, such as a double hit or a lost tag, shows up as a line that reads Invalid when it should hold a state.

// File: rtl/mesi_pkg.sv
// Shared encodings for the MESI line controller.
// Assumes 2-bit fields on every port that carries an operation code.
package mesi_pkg;
    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } line_state_e;

    typedef enum logic [1:0] {
        LOC_RD  = 2'd0,
        LOC_WR  = 2'd1,
        LOC_EV  = 2'd2,
        LOC_NOP = 2'd3
    } loc_op_e;

    typedef enum logic [1:0] {
        SNP_RD  = 2'd0,
        SNP_WR  = 2'd1,
        SNP_UPG = 2'd2,
        SNP_NOP = 2'd3
    } snp_op_e;

    typedef enum logic [1:0] {
        BUS_NONE = 2'd0,
        BUS_RD   = 2'd1,
        BUS_WR   = 2'd2,
        BUS_UPG  = 2'd3
    } bus_op_e;
endpackage

// File: rtl/mesi_tag_match.sv
// Tag lookup: finds the valid line holding a tag and returns its index and state.
// Assumes at most one valid line holds any tag (allocation only on a miss).
module mesi_tag_match
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int TAG_W     = 8,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAG_W-1:0]  tags_i [NUM_LINES],
    input  line_state_e       states_i [NUM_LINES],
    input  logic [TAG_W-1:0]  look_tag,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output line_state_e       hit_state
);
    logic [NUM_LINES-1:0] hit_vec;

    // Per-line compare against the lookup tag.
    for (genvar k = 0; k < NUM_LINES; k++) begin : g_cmp
        assign hit_vec[k] = (states_i[k] != ST_I) && (tags_i[k] == look_tag);
    end

    // Encode the matching line and pick its state.
    always_comb begin
        hit_idx = '0;
        for (int k = NUM_LINES - 1; k >= 0; k--) begin
            if (hit_vec[k]) hit_idx = IDX_W'(k);
        end
        hit       = |hit_vec;
        hit_state = hit ? states_i[hit_idx] : ST_I;
    end

    // R1: a tag lives in one line at most, so lookups are unambiguous.
    a_r1_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/mesi_local_rules.sv
// Next state and bus action for a local read, write or eviction.
// Assumes cur_i is Invalid on a miss; en_i low means nothing happens.
module mesi_local_rules
    import mesi_pkg::*;
(
    input  logic        en_i,
    input  line_state_e cur_i,
    input  logic [1:0]  op_i,
    input  logic        shared_i,
    output line_state_e nxt_o,
    output bus_op_e     bus_o,
    output logic        wb_o
);
    loc_op_e op;
    assign op = loc_op_e'(op_i);

    // Local action table.
    always_comb begin
        nxt_o = cur_i;
        bus_o = BUS_NONE;
        wb_o  = 1'b0;
        if (en_i) begin
            unique case (cur_i)
                ST_I: begin
                    if (op == LOC_RD) begin
                        bus_o = BUS_RD;
                        nxt_o = shared_i ? ST_S : ST_E;
                    end else if (op == LOC_WR) begin
                        bus_o = BUS_WR;
                        nxt_o = ST_M;
                    end
                end
                ST_S: begin
                    if (op == LOC_WR) begin
                        bus_o = BUS_UPG;
                        nxt_o = ST_M;
                    end else if (op == LOC_EV) begin
                        nxt_o = ST_I;
                    end
                end
                ST_E: begin
                    if (op == LOC_WR)      nxt_o = ST_M;
                    else if (op == LOC_EV) nxt_o = ST_I;
                end
                ST_M: begin
                    if (op == LOC_EV) begin
                        wb_o  = 1'b1;
                        nxt_o = ST_I;
                    end
                end
                default: nxt_o = cur_i;
            endcase
        end
    end
endmodule

// File: rtl/mesi_snoop_rules.sv
// Next state and response for a snooped bus read, write or upgrade.
// Assumes en_i is high only when the snooped tag hits a valid line.
module mesi_snoop_rules
    import mesi_pkg::*;
(
    input  logic        en_i,
    input  line_state_e cur_i,
    input  logic [1:0]  op_i,
    output line_state_e nxt_o,
    output logic        shared_o,
    output logic        dirty_o,
    output logic        wb_o,
    output logic        err_o
);
    snp_op_e op;
    assign op = snp_op_e'(op_i);

    // Snoop action table.
    always_comb begin
        nxt_o    = cur_i;
        shared_o = 1'b0;
        dirty_o  = 1'b0;
        wb_o     = 1'b0;
        err_o    = 1'b0;
        if (en_i) begin
            unique case (cur_i)
                ST_S: begin
                    if (op == SNP_RD)                        shared_o = 1'b1;
                    else if (op == SNP_WR || op == SNP_UPG)  nxt_o = ST_I;
                end
                ST_E: begin
                    if (op == SNP_RD) begin
                        shared_o = 1'b1;
                        nxt_o    = ST_S;
                    end else if (op == SNP_WR) begin
                        nxt_o = ST_I;
                    end else if (op == SNP_UPG) begin
                        err_o = 1'b1;
                    end
                end
                ST_M: begin
                    if (op == SNP_RD || op == SNP_WR) begin
                        dirty_o = 1'b1;
                        wb_o    = 1'b1;
                        nxt_o   = (op == SNP_RD) ? ST_S : ST_I;
                    end else if (op == SNP_UPG) begin
                        err_o = 1'b1;
                    end
                end
                default: nxt_o = cur_i;
            endcase
        end
    end
endmodule

// File: rtl/mesi_line_ctrl.sv
// MESI controller for a small fully associative set of lines.
// Outputs are combinational on the current state; states update at the next edge.
// Assumes a snoop takes the cycle: a local request alongside it is ignored.
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int TAG_W     = 8,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loc_valid,
    input  logic [1:0]       loc_op,
    input  logic [TAG_W-1:0] loc_tag,
    input  logic             shared_in,
    input  logic             snp_valid,
    input  logic [1:0]       snp_op,
    input  logic [TAG_W-1:0] snp_tag,
    output logic [1:0]       bus_op,
    output logic             resp_shared,
    output logic             resp_dirty,
    output logic             wb_valid,
    output logic             err_flag,
    output logic [1:0]       loc_state
);
    line_state_e      state_q [NUM_LINES];
    logic [TAG_W-1:0] tag_q   [NUM_LINES];

    logic             loc_hit, snp_hit, free_any, loc_en, snp_en;
    logic [IDX_W-1:0] loc_idx, snp_idx, free_idx, wr_idx;
    line_state_e      loc_cur, snp_cur, loc_nxt, snp_nxt;
    bus_op_e          loc_bus;
    logic             loc_wb, snp_wb;

    mesi_tag_match #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_loc_match (
        .clk(clk), .rst_n(rst_n), .tags_i(tag_q), .states_i(state_q),
        .look_tag(loc_tag), .hit(loc_hit), .hit_idx(loc_idx), .hit_state(loc_cur)
    );

    mesi_tag_match #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_snp_match (
        .clk(clk), .rst_n(rst_n), .tags_i(tag_q), .states_i(state_q),
        .look_tag(snp_tag), .hit(snp_hit), .hit_idx(snp_idx), .hit_state(snp_cur)
    );

    // Lowest-numbered Invalid line is the allocation victim for a miss.
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int k = NUM_LINES - 1; k >= 0; k--) begin
            if (state_q[k] == ST_I) begin
                free_any = 1'b1;
                free_idx = IDX_W'(k);
            end
        end
    end

    // Accept rules: snoop wins the cycle; a miss needs a free line.
    assign snp_en = snp_valid && snp_hit;
    assign loc_en = loc_valid && !snp_valid && (loc_hit || free_any);
    assign wr_idx = loc_hit ? loc_idx : free_idx;

    mesi_local_rules u_local (
        .en_i(loc_en), .cur_i(loc_cur), .op_i(loc_op), .shared_i(shared_in),
        .nxt_o(loc_nxt), .bus_o(loc_bus), .wb_o(loc_wb)
    );

    mesi_snoop_rules u_snoop (
        .en_i(snp_en), .cur_i(snp_cur), .op_i(snp_op), .nxt_o(snp_nxt),
        .shared_o(resp_shared), .dirty_o(resp_dirty), .wb_o(snp_wb), .err_o(err_flag)
    );

    // Commit the chosen transition and capture the tag on allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_LINES; k++) begin
                state_q[k] <= ST_I;
                tag_q[k]   <= '0;
            end
        end else if (snp_en) begin
            state_q[snp_idx] <= snp_nxt;
        end else if (loc_en) begin
            state_q[wr_idx] <= loc_nxt;
            if (!loc_hit) tag_q[wr_idx] <= loc_tag;
        end
    end

    assign bus_op    = loc_bus;
    assign wb_valid  = loc_wb | snp_wb;
    assign loc_state = loc_cur;

    // R2: a fill lands in E or S according to the sharer signal of its cycle.
    a_r2_fill_state: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_op == BUS_RD) |=> (state_q[$past(wr_idx)] == ($past(shared_in) ? ST_S : ST_E)));

    // R4: a write to an Exclusive line goes out on no bus.
    a_r4_silent_upgrade: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_valid && !snp_valid && loc_op == LOC_WR && loc_state == ST_E) |-> (bus_op == BUS_NONE));

    // R6, R7: the two snoop responses never coincide.
    a_r6_resp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_shared && resp_dirty));

    // R7: a dirty response always comes with a writeback.
    a_r7_dirty_writes_back: assert property (@(posedge clk) disable iff (!rst_n)
        resp_dirty |-> wb_valid);

    // R8: a snooped write that hits leaves the line Invalid.
    a_r8_snoop_write_inval: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_hit && snp_op == SNP_WR) |=> (state_q[$past(snp_idx)] == ST_I));

    // R9: the error flag is raised only by a snooped upgrade.
    a_r9_err_on_upgrade: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> (snp_valid && snp_op == SNP_UPG));

    // R11: a snoop cycle carries no local bus request.
    a_r11_snoop_blocks_local: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> (bus_op == BUS_NONE));
endmodule

// File: tb/mesi_line_ctrl_test.sv
// Self-checking bench: vector table walk, then reset and full-array corner cases.
module mesi_line_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       loc_valid = 1'b0;
    logic [1:0] loc_op = 2'd3;
    logic [7:0] loc_tag = 8'h00;
    logic       shared_in = 1'b0;
    logic       snp_valid = 1'b0;
    logic [1:0] snp_op = 2'd3;
    logic [7:0] snp_tag = 8'h00;
    logic [1:0] bus_op;
    logic       resp_shared, resp_dirty, wb_valid, err_flag;
    logic [1:0] loc_state;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    mesi_line_ctrl #(.NUM_LINES(4), .TAG_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .loc_valid(loc_valid), .loc_op(loc_op),
        .loc_tag(loc_tag), .shared_in(shared_in), .snp_valid(snp_valid),
        .snp_op(snp_op), .snp_tag(snp_tag), .bus_op(bus_op),
        .resp_shared(resp_shared), .resp_dirty(resp_dirty), .wb_valid(wb_valid),
        .err_flag(err_flag), .loc_state(loc_state)
    );

    typedef struct packed {
        logic       lv;
        logic [1:0] lop;
        logic [7:0] ltag;
        logic       sv;
        logic [1:0] sop;
        logic [7:0] stag;
        logic       sh;
        logic [1:0] ebus;
        logic       ers;
        logic       erd;
        logic       ewb;
        logic       eerr;
        logic [1:0] qst;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 28;
    // lv lop ltag  sv sop stag  sh | bus rs rd wb er | state-after req
    localparam vec_t TBL [NV] = '{
        '{1,0,8'h10, 0,3,8'h00, 0, 1,0,0,0,0, 2, 2},  // R2 read miss, no sharer -> E
        '{1,1,8'h10, 0,3,8'h00, 0, 0,0,0,0,0, 3, 4},  // R4 write in E, silent -> M
        '{0,3,8'h00, 1,0,8'h10, 0, 0,0,1,1,0, 1, 7},  // R7 snoop read in M -> S
        '{1,1,8'h10, 0,3,8'h00, 0, 3,0,0,0,0, 3, 3},  // R3 write in S -> upgrade, M
        '{0,3,8'h00, 1,1,8'h10, 0, 0,0,1,1,0, 0, 7},  // R7 snoop write in M -> I
        '{1,0,8'h20, 0,3,8'h00, 1, 1,0,0,0,0, 1, 2},  // R2 read miss, sharer -> S
        '{0,3,8'h00, 1,0,8'h20, 0, 0,1,0,0,0, 1, 6},  // R6 snoop read in S
        '{0,3,8'h00, 1,2,8'h20, 0, 0,0,0,0,0, 0, 8},  // R8 snoop upgrade in S -> I
        '{1,0,8'h30, 0,3,8'h00, 0, 1,0,0,0,0, 2, 2},  // R2 -> E
        '{0,3,8'h00, 1,0,8'h30, 0, 0,1,0,0,0, 1, 6},  // R6 snoop read in E -> S
        '{1,0,8'h30, 0,3,8'h00, 1, 0,0,0,0,0, 1, 4},  // R4 read hit in S
        '{1,2,8'h30, 0,3,8'h00, 0, 0,0,0,0,0, 0, 5},  // R5 evict S, no writeback
        '{1,1,8'h40, 0,3,8'h00, 0, 2,0,0,0,0, 3, 3},  // R3 write miss -> M
        '{0,3,8'h00, 1,2,8'h40, 0, 0,0,0,0,1, 3, 9},  // R9 upgrade in M -> error
        '{1,2,8'h40, 0,3,8'h00, 0, 0,0,0,1,0, 0, 5},  // R5 evict M -> writeback
        '{1,0,8'h50, 0,3,8'h00, 0, 1,0,0,0,0, 2, 2},  // R2 -> E
        '{0,3,8'h00, 1,2,8'h50, 0, 0,0,0,0,1, 2, 9},  // R9 upgrade in E -> error
        '{0,3,8'h00, 1,1,8'h50, 0, 0,0,0,0,0, 0, 8},  // R8 snoop write in E -> I
        '{0,3,8'h00, 1,0,8'h77, 0, 0,0,0,0,0, 0,10},  // R10 snoop, not held
        '{1,0,8'h60, 1,0,8'h60, 0, 0,0,0,0,0, 0,11},  // R11 local ignored in snoop cycle
        '{1,2,8'h61, 0,3,8'h00, 0, 0,0,0,0,0, 0, 5},  // R5 evict miss
        '{1,0,8'h70, 0,3,8'h00, 0, 1,0,0,0,0, 2, 2},  // R2 -> E
        '{1,0,8'h70, 0,3,8'h00, 0, 0,0,0,0,0, 2, 4},  // R4 read hit in E
        '{1,1,8'h70, 0,3,8'h00, 0, 0,0,0,0,0, 3, 4},  // R4 E -> M silent
        '{1,1,8'h70, 0,3,8'h00, 0, 0,0,0,0,0, 3, 4},  // R4 write in M
        '{1,0,8'h70, 0,3,8'h00, 0, 0,0,0,0,0, 3, 4},  // R4 read in M
        '{0,3,8'h00, 1,0,8'h70, 0, 0,0,1,1,0, 1, 7},  // R7 snoop read in M -> S
        '{0,3,8'h00, 1,1,8'h70, 0, 0,0,0,0,0, 0, 8}   // R8 snoop write in S -> I
    };

    task automatic chk(input string rq, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    task automatic idle_query(input logic [7:0] t);
        loc_valid = 1'b0; loc_op = 2'd3; loc_tag = t;
        snp_valid = 1'b0; snp_op = 2'd3; shared_in = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        idle_query(8'h10);
        repeat (2) @(negedge clk);
        #1;
        chk("R1", "reset loc_state", loc_state, 0);
        chk("R1", "reset bus_op", bus_op, 0);
        chk("R1", "reset wb/resp/err", {wb_valid, resp_shared, resp_dirty, err_flag}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            string rq;
            @(negedge clk);
            rq = $sformatf("R%0d", TBL[i].req);
            loc_valid = TBL[i].lv; loc_op = TBL[i].lop; loc_tag = TBL[i].ltag;
            snp_valid = TBL[i].sv; snp_op = TBL[i].sop; snp_tag = TBL[i].stag;
            shared_in = TBL[i].sh;
            #1;
            chk(rq, $sformatf("vec %0d bus_op", i), bus_op, TBL[i].ebus);
            chk(rq, $sformatf("vec %0d resp_shared", i), resp_shared, TBL[i].ers);
            chk(rq, $sformatf("vec %0d resp_dirty", i), resp_dirty, TBL[i].erd);
            chk(rq, $sformatf("vec %0d wb_valid", i), wb_valid, TBL[i].ewb);
            chk(rq, $sformatf("vec %0d err_flag", i), err_flag, TBL[i].eerr);
            @(negedge clk);
            idle_query(TBL[i].lv ? TBL[i].ltag : TBL[i].stag);
            #1;
            chk(rq, $sformatf("vec %0d state after", i), loc_state, TBL[i].qst);
        end

        // R12: fill all four lines, then a further miss is dropped
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            loc_valid = 1'b1; loc_op = 2'd0; loc_tag = 8'hA0 + 8'(k); shared_in = 1'b1;
            #1;
            chk("R2", "fill bus_op", bus_op, 1);
        end
        @(negedge clk);
        loc_valid = 1'b1; loc_op = 2'd1; loc_tag = 8'hA4;
        #1;
        chk("R12", "full-array miss bus_op", bus_op, 0);
        @(negedge clk);
        idle_query(8'hA4);
        #1;
        chk("R12", "full-array miss state", loc_state, 0);
        @(negedge clk);
        idle_query(8'hA3);
        #1;
        chk("R2", "last fill state", loc_state, 1);

        // R1: reset mid-run clears every line
        @(negedge clk);
        rst_n = 1'b0;
        idle_query(8'hA0);
        @(negedge clk);
        #1;
        chk("R1", "state after mid-run reset", loc_state, 0);
        rst_n = 1'b1;

        done = 1'b1;
        summary();
        $finish;
    end
endmodule